// File: doc/BRIEF.md
# Packed Lane Add/Subtract/Compare Unit

This block is a 64-bit packed-integer arithmetic stage. Each operation splits both operands into independent lanes of 8, 16 or 32 bits, chosen per operation by a size code, and applies the same operation to every lane at once. Addition and subtraction come in three flavours: modular (wrapping), signed clamping and unsigned clamping. Two compare operations produce a per-lane mask of all ones or all zeros instead of flags, so the mask can feed a later select. Four whole-word bitwise operations ignore the lane size.

An operation is presented with `in_valid` high for one cycle. Its result appears on `out_result` together with `out_valid` on the following cycle. A new operation can be presented on every cycle. When no operation is presented, the output register holds its last result and `out_valid` stays low.

Top module: `simd_alu`

## Requirements
- R1: After reset `out_valid` is 0 and `out_result` is all zeros.
- R2: An operation accepted with `in_valid` high at a clock edge drives `out_valid` high with its result after that edge. A cycle with `in_valid` low leaves `out_valid` low after the edge and `out_result` unchanged.
- R3: `in_size` selects the lane width: 0 gives eight 8-bit lanes, 1 gives four 16-bit lanes, and 2 or 3 give two 32-bit lanes. Lane i occupies bits [i*W +: W]. No carry or borrow passes from one lane into the next.
- R4: Opcode 0 (add) and opcode 3 (subtract, A minus B) keep the low W bits of each lane's sum or difference.
- R5: Opcode 1 (add) and opcode 4 (subtract) treat lanes as signed two's complement and clamp the result to 2^(W-1)-1 on positive overflow and to -2^(W-1) on negative overflow.
- R6: Opcode 2 (add) and opcode 5 (subtract) treat lanes as unsigned and clamp the result to 2^W-1 when an add overflows and to 0 when a subtract underflows.
- R7: Opcode 6 sets a lane to all ones when the A and B lanes are equal, and to all zeros otherwise.
- R8: Opcode 7 sets a lane to all ones when the A lane is greater than the B lane as a signed value, and to all zeros otherwise.
- R9: Opcodes 8 to 11 give A AND B, (NOT A) AND B, A OR B and A XOR B over all 64 bits, whatever `in_size` holds.
- R10: Opcodes 12 to 15 give an all-zero result.
- R11: With 8-bit lanes, the bitwise OR of the opcode 5 results for (A, B) and for (B, A) equals the absolute difference of A and B in every byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present on this cycle |
| in_op | input | 4 | Opcode |
| in_size | input | 2 | Lane width code |
| in_a | input | 64 | Operand A |
| in_b | input | 64 | Operand B |
| out_valid | output | 1 | Result valid |
| out_result | output | 64 | Registered result |

## Verification
On every cycle the assertions check the handshake timing and the hold of the result register when idle. They also check the relations that hold for any operands: equal operands give an all-ones equality mask and an all-zero greater-than mask and XOR, reserved opcodes give zero, and byte-wise unsigned clamping never falls below A on add or rises above A on subtract. The exact clamp values, the isolation of carries at each lane width, the signed ordering of the compare and the absolute-difference identity depend on particular operand values, so only the bench's directed and random scenarios can show them.

// File: rtl/simd_pkg.sv
package simd_pkg;

    localparam int DATA_W = 64;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_ALT   = 2'd3
    } lane_sz_e;

    typedef enum logic [3:0] {
        OP_ADD    = 4'd0,
        OP_ADDS   = 4'd1,
        OP_ADDUS  = 4'd2,
        OP_SUB    = 4'd3,
        OP_SUBS   = 4'd4,
        OP_SUBUS  = 4'd5,
        OP_CMPEQ  = 4'd6,
        OP_CMPGT  = 4'd7,
        OP_AND    = 4'd8,
        OP_ANDN   = 4'd9,
        OP_OR     = 4'd10,
        OP_XOR    = 4'd11
    } alu_op_e;

    typedef enum logic [1:0] {
        CLAMP_NONE = 2'd0,
        CLAMP_SGN  = 2'd1,
        CLAMP_UNS  = 2'd2
    } clamp_e;

endpackage

// File: rtl/lane_addsub.sv
module lane_addsub
    import simd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic [1:0]   mode,
    output logic [W-1:0] y
);
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0]   raw;
    logic [W-1:0] low;
    logic         carry;
    logic         sovf;

    always_comb begin
        raw   = sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
        low   = raw[W-1:0];
        carry = raw[W];
        if (sub)
            sovf = (a[W-1] != b[W-1]) && (low[W-1] != a[W-1]);
        else
            sovf = (a[W-1] == b[W-1]) && (low[W-1] != a[W-1]);

        case (mode)
            CLAMP_SGN: y = sovf ? (a[W-1] ? SMIN : SMAX) : low;
            CLAMP_UNS: y = carry ? (sub ? '0 : '1) : low;
            default:   y = low;
        endcase
    end
endmodule

// File: rtl/lane_cmp.sv
module lane_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] eq_m,
    output logic [W-1:0] gt_m
);
    always_comb begin
        eq_m = {W{a == b}};
        gt_m = {W{$signed(a) > $signed(b)}};
    end
endmodule

// File: rtl/lane_bank.sv
module lane_bank #(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    input  logic [1:0]        mode,
    output logic [DATA_W-1:0] y_arith,
    output logic [DATA_W-1:0] y_eq,
    output logic [DATA_W-1:0] y_gt
);
    localparam int NLANES = DATA_W / LANE_W;

    for (genvar i = 0; i < NLANES; i++) begin : g_lane
        lane_addsub #(.W(LANE_W)) u_as (
            .a    (a[i*LANE_W +: LANE_W]),
            .b    (b[i*LANE_W +: LANE_W]),
            .sub  (sub),
            .mode (mode),
            .y    (y_arith[i*LANE_W +: LANE_W])
        );
        lane_cmp #(.W(LANE_W)) u_cmp (
            .a    (a[i*LANE_W +: LANE_W]),
            .b    (b[i*LANE_W +: LANE_W]),
            .eq_m (y_eq[i*LANE_W +: LANE_W]),
            .gt_m (y_gt[i*LANE_W +: LANE_W])
        );
    end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
    import simd_pkg::*;
#(
    parameter int DATA_W = simd_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        in_op,
    input  logic [1:0]        in_size,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result
);
    localparam int NSIZES = 3;
    localparam int LANE_W [NSIZES] = '{8, 16, 32};

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
    } stage_t;

    stage_t st_d, st_q;

    logic       dec_sub;
    logic [1:0] dec_mode;

    logic [DATA_W-1:0] bank_as [NSIZES];
    logic [DATA_W-1:0] bank_eq [NSIZES];
    logic [DATA_W-1:0] bank_gt [NSIZES];

    // Opcode decode shared by every lane of every bank
    always_comb begin
        dec_sub  = (in_op == OP_SUB) || (in_op == OP_SUBS) || (in_op == OP_SUBUS);
        case (in_op)
            OP_ADDS, OP_SUBS:   dec_mode = CLAMP_SGN;
            OP_ADDUS, OP_SUBUS: dec_mode = CLAMP_UNS;
            default:            dec_mode = CLAMP_NONE;
        endcase
    end

    for (genvar s = 0; s < NSIZES; s++) begin : g_bank
        lane_bank #(.DATA_W(DATA_W), .LANE_W(LANE_W[s])) u_bank (
            .a       (in_a),
            .b       (in_b),
            .sub     (dec_sub),
            .mode    (dec_mode),
            .y_arith (bank_as[s]),
            .y_eq    (bank_eq[s]),
            .y_gt    (bank_gt[s])
        );
    end

    always_comb begin
        int sel;
        logic [DATA_W-1:0] r;
        case (in_size)
            SZ_BYTE: sel = 0;
            SZ_WORD: sel = 1;
            default: sel = 2;
        endcase
        case (in_op)
            OP_ADD, OP_ADDS, OP_ADDUS,
            OP_SUB, OP_SUBS, OP_SUBUS: r = bank_as[sel];
            OP_CMPEQ:                  r = bank_eq[sel];
            OP_CMPGT:                  r = bank_gt[sel];
            OP_AND:                    r = in_a & in_b;
            OP_ANDN:                   r = ~in_a & in_b;
            OP_OR:                     r = in_a | in_b;
            OP_XOR:                    r = in_a ^ in_b;
            default:                   r = '0;
        endcase

        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid)
            st_d.res = r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_valid  = st_q.vld;
    assign out_result = st_q.res;
endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [3:0]        in_op,
    input logic [1:0]        in_size,
    input logic [DATA_W-1:0] in_a,
    input logic [DATA_W-1:0] in_b,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result
);
    localparam int NBYTES = DATA_W / 8;

    p_reset_clear_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (!out_valid && out_result == '0));

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_result)));

    p_eq_self_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 4'd6 && in_a == in_b) |=> (out_result == '1));

    p_gt_self_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 4'd7 && in_a == in_b) |=> (out_result == '0));

    p_xor_self_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 4'd11 && in_a == in_b) |=> (out_result == '0));

    p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op >= 4'd12) |=> (out_result == '0));

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        p_uadd_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_op == 4'd2 && in_size == 2'd0)
            |=> (out_result[i*8 +: 8] >= $past(in_a[i*8 +: 8])));

        p_usub_ceiling_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_op == 4'd5 && in_size == 2'd0)
            |=> (out_result[i*8 +: 8] <= $past(in_a[i*8 +: 8])));
    end
endmodule

bind simd_alu simd_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_size    (in_size),
    .in_a       (in_a),
    .in_b       (in_b),
    .out_valid  (out_valid),
    .out_result (out_result)
);

// File: tb/simd_alu_test.sv
module simd_alu_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_op = '0;
    logic [1:0]  in_size = '0;
    logic [63:0] in_a = '0;
    logic [63:0] in_b = '0;
    logic        out_valid;
    logic [63:0] out_result;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    typedef struct {
        logic [63:0] exp;
        string       tag;
    } item_t;

    item_t       sb[$];
    logic [63:0] last_res = '0;
    logic [63:0] prev_res = '0;
    bit          live = 0;

    always #4 clk = ~clk;

    simd_alu uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_op      (in_op),
        .in_size    (in_size),
        .in_a       (in_a),
        .in_b       (in_b),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    // Expected value built lane by lane from the requirements
    function automatic logic [63:0] model(input logic [3:0] op, input logic [1:0] sz,
                                          input logic [63:0] a, input logic [63:0] b);
        int w;
        longint m, hi, lo, ua, ub, sa, sb_, t;
        logic [63:0] r;
        w  = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        m  = (longint'(1) << w) - 1;
        hi = (longint'(1) << (w - 1)) - 1;
        lo = -(longint'(1) << (w - 1));
        r  = '0;
        case (op)
            4'd8:  return a & b;
            4'd9:  return ~a & b;
            4'd10: return a | b;
            4'd11: return a ^ b;
            default: ;
        endcase
        if (op >= 4'd12) return '0;
        for (int i = 0; i < 64 / w; i++) begin
            ua  = longint'(a >> (i * w)) & m;
            ub  = longint'(b >> (i * w)) & m;
            sa  = (ua > hi) ? ua - (longint'(1) << w) : ua;
            sb_ = (ub > hi) ? ub - (longint'(1) << w) : ub;
            case (op)
                4'd0: t = ua + ub;
                4'd3: t = ua - ub;
                4'd1: begin t = sa + sb_; if (t > hi) t = hi; if (t < lo) t = lo; end
                4'd4: begin t = sa - sb_; if (t > hi) t = hi; if (t < lo) t = lo; end
                4'd2: begin t = ua + ub; if (t > m) t = m; end
                4'd5: begin t = ua - ub; if (t < 0) t = 0; end
                4'd6: t = (ua == ub) ? m : 0;
                4'd7: t = (sa > sb_) ? m : 0;
                default: t = 0;
            endcase
            r = r | (64'(t & m) << (i * w));
        end
        return r;
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [3:0] op, input logic [1:0] sz,
                        input logic [63:0] a, input logic [63:0] b, input string tag);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1;
        in_op    = op;
        in_size  = sz;
        in_a     = a;
        in_b     = b;
        it.exp   = model(op, sz, a, b);
        it.tag   = tag;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_op    = 4'($urandom_range(0, 15));
            in_a     = {$urandom, $urandom};
        end
    endtask

    // Monitor: compare each produced result with the oldest expectation
    always @(negedge clk) begin
        if (rst_n && live) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R2 unexpected out_valid", out_result, '0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    check(out_result == it.exp, it.tag, out_result, it.exp);
                end
                prev_res = last_res;
                last_res = out_result;
            end else begin
                check(out_result == last_res, "R2 hold while idle", out_result, last_res);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [63:0] x, y, ad;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid after reset", {63'd0, out_valid}, '0);
        check(out_result == '0, "R1 result after reset", out_result, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid after release", {63'd0, out_valid}, '0);
        live = 1;

        // R3 / R4: wrap and lane isolation at every width
        send(4'd0, 2'd0, 64'h00FF_00FF_FFFF_FFFF, 64'h0001_0001_0001_0001, "R3 R4 add wrap bytes");
        send(4'd0, 2'd1, 64'h00FF_00FF_FFFF_FFFF, 64'h0001_0001_0001_0001, "R3 R4 add wrap words");
        send(4'd0, 2'd2, 64'hFFFF_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, "R3 R4 add wrap dwords");
        send(4'd3, 2'd0, 64'h0000_0000_0100_0000, 64'h0101_0101_0101_0101, "R3 R4 sub wrap bytes");
        send(4'd3, 2'd1, 64'h0000_0000_0001_0000, 64'h0001_0001_0001_0001, "R4 sub wrap words");
        send(4'd3, 2'd3, 64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001, "R3 size 3 as dwords");
        // R5 signed clamps
        send(4'd1, 2'd0, 64'h7F80_7F80_0102_7F80, 64'h01FF_7F80_0102_0101, "R5 add signed bytes");
        send(4'd1, 2'd1, 64'h7FFF_8000_1234_7FFF, 64'h0001_FFFF_1111_8000, "R5 add signed words");
        send(4'd1, 2'd2, 64'h7FFF_FFFF_8000_0000, 64'h0000_0001_8000_0000, "R5 add signed dwords");
        send(4'd4, 2'd0, 64'h807F_8000_7F05_7F80, 64'h01FF_7F80_8003_0101, "R5 sub signed bytes");
        send(4'd4, 2'd1, 64'h8000_7FFF_0005_0000, 64'h0001_FFFF_0009_8000, "R5 sub signed words");
        // R6 unsigned clamps
        send(4'd2, 2'd0, 64'hFF80_01FE_0000_7F10, 64'h0180_FF01_0000_8020, "R6 add unsigned bytes");
        send(4'd2, 2'd1, 64'hFFFF_8000_0001_1234, 64'h0001_8000_FFFE_0001, "R6 add unsigned words");
        send(4'd5, 2'd0, 64'h0102_FF00_8080_1020, 64'h0201_00FF_8180_1010, "R6 sub unsigned bytes");
        send(4'd5, 2'd2, 64'h0000_0001_FFFF_FFFF, 64'h0000_0002_0000_0001, "R6 sub unsigned dwords");
        // R7 / R8 masks
        send(4'd6, 2'd0, 64'h1122_3344_5566_7788, 64'h1100_3300_5500_7700, "R7 eq bytes partial");
        send(4'd6, 2'd1, 64'h1122_3344_5566_7788, 64'h1122_0044_5566_7700, "R7 eq words partial");
        send(4'd7, 2'd0, 64'h807F_0001_FF00_7F7F, 64'h7F80_0100_00FF_7F7E, "R8 gt signed bytes");
        send(4'd7, 2'd1, 64'h8000_7FFF_0001_FFFF, 64'h7FFF_8000_0001_FFFE, "R8 gt signed words");
        send(4'd7, 2'd2, 64'h8000_0000_0000_0001, 64'h7FFF_FFFF_0000_0000, "R8 gt signed dwords");
        // R9 logic ignores size, R10 reserved
        send(4'd8,  2'd0, 64'hF0F0_1234_FFFF_0000, 64'hFF00_00FF_5A5A_FFFF, "R9 and");
        send(4'd9,  2'd1, 64'hF0F0_1234_FFFF_0000, 64'hFF00_00FF_5A5A_FFFF, "R9 andn");
        send(4'd10, 2'd2, 64'hF0F0_1234_FFFF_0000, 64'hFF00_00FF_5A5A_FFFF, "R9 or");
        send(4'd11, 2'd3, 64'hF0F0_1234_FFFF_0000, 64'hFF00_00FF_5A5A_FFFF, "R9 xor");
        send(4'd12, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF, "R10 op 12");
        send(4'd15, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF, "R10 op 15");
        idle(3);

        // R11 absolute difference identity, several operand pairs
        for (int n = 0; n < 6; n++) begin
            x = (n == 0) ? 64'h00FF_1080_7F01_2233 : {$urandom, $urandom};
            y = (n == 0) ? 64'hFF00_8010_017F_2233 : {$urandom, $urandom};
            send(4'd5, 2'd0, x, y, "R11 sub unsigned A-B");
            send(4'd5, 2'd0, y, x, "R11 sub unsigned B-A");
            idle(2);
            ad = '0;
            for (int i = 0; i < 8; i++) begin
                logic [7:0] p, q;
                p = x[i*8 +: 8];
                q = y[i*8 +: 8];
                ad[i*8 +: 8] = (p > q) ? p - q : q - p;
            end
            check((prev_res | last_res) == ad, "R11 OR of clamped differences",
                  prev_res | last_res, ad);
        end

        // Random mix across all opcodes and sizes, with idle gaps (R2)
        for (int n = 0; n < 400; n++) begin
            logic [63:0] ra, rb;
            ra = {$urandom, $urandom};
            rb = (n % 7 == 0) ? ra : {$urandom, $urandom};
            send(4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)), ra, rb, "R3-mix random op");
            if (n % 9 == 0) idle(1);
        end
        idle(3);
        check(sb.size() == 0, "R2 all results delivered", 64'(sb.size()), '0);
        summary();
    end

endmodule